// File: doc/BRIEF.md
# Four-Region External Memory Bus Controller

This controller links a simple internal request port to an external asynchronous or synchronous memory bus that has four chip-select regions. The top two bits of the internal address choose a region. Each region holds an 8-bit setting that fixes four things: how many clock cycles each bus beat lasts, whether the memory is marked synchronous, whether writes are allowed, and how wide the external data path is. A 32-bit or 16-bit internal access to a narrower region is split into several bus beats. The beats go out lowest address first, and each one holds the strobes for the programmed number of cycles.

Software reaches the region settings through a small register port. The settings are protected by a guard register. Writes to the settings take effect only after a fixed unlock word has been written to the guard. A write to the guard with any other value locks the settings again.

When a write targets a region without write permission, the write strobe is never asserted. The access still completes normally on the internal side, reports an error with its completion, and sets a sticky status bit that software can read and clear.

Top module: `extbus_ctrl`

## Requirements
- R1: After reset, every region setting reads 0xF0 (16-cycle beats, asynchronous, writes disabled, 8-bit). The guard reads 1 (locked) and status reads 0. All chip selects and strobes are high and `req_ready` is 1.
- R2: Writing 0x0000A05F to offset 0x20 unlocks the settings, and 0x20 then reads 0. Writing any other value to 0x20 locks them, and 0x20 then reads 1.
- R3: Region k's setting lives at offset 4*k. While locked, writes to it are ignored. While unlocked, a write stores bits [7:0]. Reads return the stored byte with bits [31:8] at zero.
- R4: Setting bits [7:4] hold a wait code c. Every bus beat lasts min(c+2, 16) cycles.
- R5: `req_addr[27:26]` selects region k. During the access only `ext_cs_n[k]` is low. `ext_addr` is `req_addr[25:0]` plus the byte offset of the current beat.
- R6: Setting bits [1:0] set the lane width: 0 gives 1 byte, 1 gives 2 bytes, 2 and 3 give 4 bytes. `req_size` 0/1/2 is a 1/2/4-byte access. The access uses max(1, size/lane) beats, lowest address first, each beat advancing `ext_addr` by the lane width.
- R7: On a write beat k, `ext_wdata` carries request bytes starting at k*lane, right-justified on the bus. Lanes beyond min(lane, size) are zero.
- R8: On a read, beat k's lanes are placed at byte k*lane of `rsp_rdata`. Bytes at and above the access size are zero. `rsp_done` pulses for one cycle, the cycle after the last beat.
- R9: If setting bit 2 is 0, a write keeps `ext_we_n` high for the whole access, still takes the full beat timing, and completes with `rsp_err`=1. Permitted writes assert `ext_we_n` low on every beat.
- R10: Offset 0x24 bit 0 is a sticky error flag. It is set by a blocked write and cleared by any write to 0x24.
- R11: During an access, `ext_sync` equals setting bit 3 of the selected region. `ext_oe_n` is low on every read beat and high on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Internal access request |
| req_ready | output | 1 | Controller idle, request taken when valid |
| req_addr | input | 28 | Internal byte address; [27:26] pick the region |
| req_wdata | input | 32 | Write data, right-justified |
| req_size | input | 2 | Access size code: 0 byte, 1 half, 2 word |
| req_write | input | 1 | 1 write, 0 read |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, right-justified |
| rsp_err | output | 1 | Completion was a blocked write |
| ext_cs_n | output | 4 | Active-low chip selects |
| ext_addr | output | 26 | External byte address |
| ext_wdata | output | 32 | External write data |
| ext_rdata | input | 32 | External read data |
| ext_we_n | output | 1 | Active-low write strobe |
| ext_oe_n | output | 1 | Active-low output enable |
| ext_sync | output | 1 | Selected region is synchronous |

## Verification
The assertions check a set of properties on every cycle:
- chip selects are never more than one-hot;
- the beat counter stays within the latched wait length;
- completion pulses stay single;
- a blocked-write completion always follows a cycle with the write strobe high;
- locked settings never move;
- only the exact unlock word releases the guard;
- the sticky flag holds until it is cleared.

Beat counts, per-beat addresses and data lanes, read assembly, and the exact number of strobe cycles can only be shown by the bench. The bench sweeps every region, lane width, access size, several wait codes and both directions.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

  localparam logic [7:0] CFG_RESET = 8'hF0;

  // beat length in cycles for a wait code
  function automatic logic [4:0] wait_cycles(input logic [3:0] code);
    logic [4:0] n;
    n = {1'b0, code} + 5'd2;
    return (n > 5'd16) ? 5'd16 : n;
  endfunction

  // bytes carried per beat for a lane width code
  function automatic logic [2:0] lane_bytes(input logic [1:0] wcode);
    case (wcode)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // bytes in an internal access for a size code
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [2:0] beat_count(input logic [1:0] sz, input logic [1:0] wcode);
    logic [2:0] sb, lb;
    sb = size_bytes(sz);
    lb = lane_bytes(wcode);
    return (sb <= lb) ? 3'd1 : sb / lb;
  endfunction

  function automatic logic [31:0] byte_mask(input logic [2:0] nbytes);
    case (nbytes)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/extbus_cfg_regs.sv
module extbus_cfg_regs
  import extbus_pkg::*;
#(
  parameter int CS_N    = 4,
  parameter int RADDR_W = 6,
  parameter logic [31:0] MAGIC = 32'h0000_A05F
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [RADDR_W-1:0]       reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic                     blocked_evt,
  output logic [CS_N-1:0][7:0]     cfg_q
);

  localparam logic [RADDR_W-1:0] GUARD_OFF  = RADDR_W'(32);
  localparam logic [RADDR_W-1:0] STATUS_OFF = RADDR_W'(36);

  logic locked;
  logic err_q;
  logic guard_wr, status_wr;

  assign guard_wr  = reg_we && (reg_addr == GUARD_OFF);
  assign status_wr = reg_we && (reg_addr == STATUS_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        locked <= 1'b1;
    else if (guard_wr) locked <= (reg_wdata != MAGIC);
  end

  // error set wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           err_q <= 1'b0;
    else if (blocked_evt) err_q <= 1'b1;
    else if (status_wr)   err_q <= 1'b0;
  end

  for (genvar g = 0; g < CS_N; g++) begin : g_region
    localparam logic [RADDR_W-1:0] OFF = RADDR_W'(4 * g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 cfg_q[g] <= CFG_RESET;
      else if (reg_we && !locked && reg_addr == OFF) cfg_q[g] <= reg_wdata[7:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == GUARD_OFF)       reg_rdata = {31'b0, locked};
    else if (reg_addr == STATUS_OFF) reg_rdata = {31'b0, err_q};
    else begin
      for (int i = 0; i < CS_N; i++)
        if (reg_addr == RADDR_W'(4 * i)) reg_rdata = {24'b0, cfg_q[i]};
    end
  end

  AST_LOCK_FREEZES_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(cfg_q)); // R3

  AST_UNLOCK_NEEDS_MAGIC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(reg_we && reg_addr == GUARD_OFF && reg_wdata == MAGIC)); // R2

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !status_wr) |=> err_q); // R10

endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
  import extbus_pkg::*;
#(
  parameter int CS_N = 4,
  parameter int LA_W = 26,
  localparam int CSEL_W = $clog2(CS_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LA_W-1:0]   req_laddr,
  input  logic [CSEL_W-1:0] req_cs,
  input  logic [7:0]        req_cfg,
  input  logic [31:0]       req_wdata,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  output logic              rsp_done,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              blocked_evt,
  output logic [CS_N-1:0]   ext_cs_n,
  output logic [LA_W-1:0]   ext_addr,
  output logic [31:0]       ext_wdata,
  input  logic [31:0]       ext_rdata,
  output logic              ext_we_n,
  output logic              ext_oe_n,
  output logic              ext_sync
);

  logic              busy;
  logic [1:0]        beat_idx, beats_m1;
  logic [4:0]        cyc, lat_wait;
  logic [2:0]        lat_lane;
  logic [31:0]       lat_mask, lat_size_mask;
  logic              lat_write, lat_block, lat_sync;
  logic [CSEL_W-1:0] lat_cs;
  logic [LA_W-1:0]   base;
  logic [31:0]       wbuf, rbuf;

  logic       accept, beat_end, last_beat;
  logic [4:0] beat_off;
  logic [7:0] shift_bits;
  logic [31:0] rbuf_next;
  logic [2:0] req_lanes;

  assign req_ready   = !busy;
  assign accept      = req_valid && !busy;
  assign blocked_evt = accept && req_write && !req_cfg[2];
  assign beat_end    = busy && (cyc == lat_wait - 5'd1);
  assign last_beat   = beat_end && (beat_idx == beats_m1);
  assign beat_off    = {3'b0, beat_idx} * {2'b0, lat_lane};
  assign shift_bits  = {beat_off, 3'b000};
  assign rbuf_next   = rbuf | ((ext_rdata & lat_mask) << shift_bits);
  assign req_lanes   = (size_bytes(req_size) < lane_bytes(req_cfg[1:0])) ?
                       size_bytes(req_size) : lane_bytes(req_cfg[1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; beat_idx <= '0; beats_m1 <= '0; cyc <= '0; lat_wait <= 5'd16;
      lat_lane <= 3'd1; lat_mask <= '0; lat_size_mask <= '0; lat_write <= 1'b0;
      lat_block <= 1'b0; lat_sync <= 1'b0; lat_cs <= '0; base <= '0;
      wbuf <= '0; rbuf <= '0; rsp_done <= 1'b0; rsp_err <= 1'b0; rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      rsp_err  <= 1'b0;
      if (accept) begin
        busy          <= 1'b1;
        beat_idx      <= '0;
        cyc           <= '0;
        beats_m1      <= 2'(beat_count(req_size, req_cfg[1:0]) - 3'd1);
        lat_wait      <= wait_cycles(req_cfg[7:4]);
        lat_lane      <= lane_bytes(req_cfg[1:0]);
        lat_mask      <= byte_mask(req_lanes);
        lat_size_mask <= byte_mask(size_bytes(req_size));
        lat_write     <= req_write;
        lat_block     <= req_write && !req_cfg[2];
        lat_sync      <= req_cfg[3];
        lat_cs        <= req_cs;
        base          <= req_laddr;
        wbuf          <= req_wdata;
        rbuf          <= '0;
      end else if (busy) begin
        if (beat_end) begin
          cyc <= '0;
          if (!lat_write) rbuf <= rbuf_next;
          if (last_beat) begin
            busy      <= 1'b0;
            rsp_done  <= 1'b1;
            rsp_err   <= lat_block;
            rsp_rdata <= lat_write ? 32'b0 : (rbuf_next & lat_size_mask);
          end else begin
            beat_idx <= beat_idx + 2'd1;
          end
        end else begin
          cyc <= cyc + 5'd1;
        end
      end
    end
  end

  assign ext_cs_n  = busy ? ~(CS_N'(1) << lat_cs) : '1;
  assign ext_addr  = busy ? base + LA_W'(beat_off) : '0;
  assign ext_wdata = (busy && lat_write) ? ((wbuf >> shift_bits) & lat_mask) : '0;
  assign ext_we_n  = !(busy && lat_write && !lat_block);
  assign ext_oe_n  = !(busy && !lat_write);
  assign ext_sync  = busy && lat_sync;

  AST_BEAT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cyc < lat_wait)); // R4

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R8

  AST_BLOCKED_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_err) |-> $past(ext_we_n)); // R9

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_we_n && !ext_oe_n)); // R11

endmodule

// File: rtl/extbus_ctrl.sv
module extbus_ctrl
  import extbus_pkg::*;
#(
  parameter int ADDR_W  = 28,
  parameter int CS_N    = 4,
  parameter int RADDR_W = 6,
  localparam int CSEL_W = $clog2(CS_N),
  localparam int LA_W   = ADDR_W - CSEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [31:0]        req_wdata,
  input  logic [1:0]         req_size,
  input  logic               req_write,
  output logic               rsp_done,
  output logic [31:0]        rsp_rdata,
  output logic               rsp_err,
  output logic [CS_N-1:0]    ext_cs_n,
  output logic [LA_W-1:0]    ext_addr,
  output logic [31:0]        ext_wdata,
  input  logic [31:0]        ext_rdata,
  output logic               ext_we_n,
  output logic               ext_oe_n,
  output logic               ext_sync
);

  logic [CS_N-1:0][7:0] cfg_q;
  logic [CSEL_W-1:0]    req_cs;
  logic                 blocked_evt;

  assign req_cs = req_addr[ADDR_W-1 -: CSEL_W];

  extbus_cfg_regs #(.CS_N(CS_N), .RADDR_W(RADDR_W)) u_cfg (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .blocked_evt, .cfg_q
  );

  extbus_seq #(.CS_N(CS_N), .LA_W(LA_W)) u_seq (
    .clk, .rst_n, .req_valid, .req_ready,
    .req_laddr(req_addr[LA_W-1:0]), .req_cs, .req_cfg(cfg_q[req_cs]),
    .req_wdata, .req_size, .req_write,
    .rsp_done, .rsp_rdata, .rsp_err, .blocked_evt,
    .ext_cs_n, .ext_addr, .ext_wdata, .ext_rdata,
    .ext_we_n, .ext_oe_n, .ext_sync
  );

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ext_cs_n)); // R5

  AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_we_n || !ext_oe_n) |-> ($countones(~ext_cs_n) == 1)); // R5

endmodule

// File: tb/extbus_ctrl_test.sv
`timescale 1ns/1ps
module extbus_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [27:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic        rsp_done, rsp_err;
  logic [31:0] rsp_rdata;
  logic [3:0]  ext_cs_n;
  logic [25:0] ext_addr;
  logic [31:0] ext_wdata, ext_rdata;
  logic        ext_we_n, ext_oe_n, ext_sync;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  extbus_ctrl uut (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .req_valid, .req_ready, .req_addr, .req_wdata, .req_size, .req_write,
    .rsp_done, .rsp_rdata, .rsp_err,
    .ext_cs_n, .ext_addr, .ext_wdata, .ext_rdata, .ext_we_n, .ext_oe_n, .ext_sync
  );

  // external memory model: byte at address a reads (a[7:0]) ^ 0x5A
  always_comb
    for (int i = 0; i < 4; i++) ext_rdata[i*8 +: 8] = (ext_addr[7:0] + 8'(i)) ^ 8'h5A;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; #1;
    d = reg_rdata;
  endtask

  function automatic int lane_of(input int wc);
    return (wc == 0) ? 1 : (wc == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] mask_of(input int n);
    return (n >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 32'h1);
  endfunction

  task automatic access(input int r, input logic [25:0] la, input int sz, input bit wr,
                        input logic [31:0] wd, input int wc, input int wcode,
                        input bit wen, input bit sync);
    int n_cyc, lane, sbytes, beats, lanes, c, k;
    int bad_cs, bad_addr, bad_data, bad_strobe, bad_sync;
    logic [31:0] exp_rd;
    n_cyc  = (wcode + 2 > 16) ? 16 : wcode + 2;
    lane   = lane_of(wc);
    sbytes = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    beats  = (sbytes <= lane) ? 1 : sbytes / lane;
    lanes  = (sbytes < lane) ? sbytes : lane;
    bad_cs = 0; bad_addr = 0; bad_data = 0; bad_strobe = 0; bad_sync = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = {2'(r), la}; req_size = 2'(sz);
    req_write = wr; req_wdata = wd;
    @(posedge clk); #1;
    req_valid = 1'b0;
    c = 0;
    forever begin
      @(negedge clk);
      if (rsp_done || c > 200) break;
      k = c / n_cyc;
      if (ext_cs_n !== ~(4'b1 << r)) bad_cs++;
      if (ext_addr !== la + 26'(k * lane)) bad_addr++;
      if (wr && ext_wdata !== ((wd >> (8 * lane * k)) & mask_of(lanes))) bad_data++;
      if (ext_we_n !== !(wr && wen) || ext_oe_n !== wr) bad_strobe++;
      if (ext_sync !== sync) bad_sync++;
      c++;
    end
    chk("R4 strobe cycles", 32'(c), 32'(beats * n_cyc));
    chk("R5 chip select", 32'(bad_cs), 0);
    chk("R6 beat address", 32'(bad_addr), 0);
    if (wr) chk("R7 write lanes", 32'(bad_data), 0);
    chk(wr ? "R9 write strobe" : "R11 read strobe", 32'(bad_strobe), 0);
    chk("R11 sync flag", 32'(bad_sync), 0);
    chk("R9 response error", 32'(rsp_err), 32'(wr && !wen));
    if (!wr) begin
      exp_rd = '0;
      for (int j = 0; j < sbytes; j++) exp_rd[8*j +: 8] = (la[7:0] + 8'(j)) ^ 8'h5A;
      chk("R8 read assembly", rsp_rdata, exp_rd);
    end
    @(negedge clk);
    chk("R8 done single", 32'(rsp_done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int codes [5] = '{0, 3, 13, 14, 15};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int r = 0; r < 4; r++) begin
      reg_rd(6'(4 * r), v); chk("R1 cfg reset", v, 32'h0000_00F0);
    end
    reg_rd(6'h20, v); chk("R1 lock reset", v, 1);
    reg_rd(6'h24, v); chk("R1 status reset", v, 0);
    chk("R1 idle pins", {27'b0, ext_cs_n, ext_we_n}, {27'b0, 4'hF, 1'b1});
    chk("R1 idle oe/ready", {30'b0, ext_oe_n, req_ready}, 32'h3);

    // R2 / R3 guard behaviour
    reg_wr(6'h00, 32'h0000_000A);
    reg_rd(6'h00, v); chk("R3 locked write ignored", v, 32'hF0);
    reg_wr(6'h20, 32'h0000_A05F);
    reg_rd(6'h20, v); chk("R2 unlock", v, 0);
    reg_wr(6'h00, 32'hFFFF_FF2A);
    reg_rd(6'h00, v); chk("R3 unlocked write", v, 32'h2A);
    reg_wr(6'h20, 32'h0000_1234);
    reg_rd(6'h20, v); chk("R2 relock", v, 1);
    reg_wr(6'h00, 32'h0000_0005);
    reg_rd(6'h00, v); chk("R3 relocked write ignored", v, 32'h2A);
    reg_wr(6'h20, 32'h0001_A05F);
    reg_rd(6'h20, v); chk("R2 near-miss stays locked", v, 1);
    reg_wr(6'h20, 32'h0000_A05F);

    // sweep regions, lane widths, wait codes, sizes, directions
    for (int r = 0; r < 4; r++)
      for (int wc = 0; wc < 4; wc++)
        for (int wi = 0; wi < 5; wi++) begin
          automatic int  wcode = codes[wi];
          automatic bit  sync  = wi[0];
          automatic logic [7:0] cfg = {4'(wcode), sync, 1'b1, 2'(wc)};
          automatic logic [25:0] la = 26'h012_3440 + 26'(16 * wi + 4 * r);
          reg_wr(6'(4 * r), {24'hABCDEF, cfg});
          reg_rd(6'(4 * r), v); chk("R3 cfg readback", v, {24'b0, cfg});
          for (int sz = 0; sz < 3; sz++) begin
            access(r, la, sz, 1'b0, '0, wc, wcode, 1'b1, sync);
            access(r, la, sz, 1'b1, 32'hC3A5_1E69 ^ 32'(r * 4099 + wc * 257 + wi),
                   wc, wcode, 1'b1, sync);
          end
          // write-protected region
          reg_wr(6'(4 * r), {24'b0, cfg & 8'hFB});
          access(r, la, 2, 1'b1, 32'h1122_3344, wc, wcode, 1'b0, sync);
          reg_rd(6'h24, v); chk("R10 sticky set", v, 1);
          access(r, la, 0, 1'b0, '0, wc, wcode, 1'b0, sync);
          reg_rd(6'h24, v); chk("R10 sticky held", v, 1);
          reg_wr(6'h24, 32'h0);
          reg_rd(6'h24, v); chk("R10 sticky cleared", v, 0);
        end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule